// File: doc/BRIEF.md
# Four-Output Steered PWM Generator

The block produces one pulse-width-modulated waveform and routes it onto four output pins. A free-running 8-bit count, paced by a selectable clock divider, climbs from zero to a programmable period limit and then restarts. Two sub-phase bits below the count give the duty comparison 10 bits of resolution. The modulated signal is asserted at the start of each period and stays asserted until the extended count reaches the duty value. A period-complete flag marks each restart.

A steering field places the waveform onto the pins in one of four arrangements. Single mode drives one pin. Half-bridge mode drives a complementary pair with a programmable dead gap at every transition. The two full-bridge modes each hold one pin steadily active and modulate a diagonal partner. A per-pin polarity mask makes any output active-low.

Software reaches the block through a flat register port: a write strobe, a 3-bit address, 8-bit write data and combinational read data. A duty value that is written in mid-period waits in a staging register and only takes effect at the next restart. This lets software set up the outputs and then wait for a clean cycle boundary before it relies on them.

Top module: `steer_pwm`

## Requirements
- R1: After reset, the period register (address 0) reads 8'hFF. Duty (1), control (2), dead gap (3), timer control (4), status (5) and count (6) all read 0, and all four pins are low.
- R2: Timer control (address 4) bit 2 enables counting and bits 1:0 pick the divider: 00 gives /1, 01 gives /4, and 1x gives /16. The count takes values 0..P, where P is the period register, and each value lasts 4 × divider clocks. One PWM period is therefore 4·(P+1)·divider clocks.
- R3: Control bits 7:6 = 00 (single) drives the waveform on pin 0 only. With divider /1, pin 0 is active for exactly D clocks per period, and pins 1..3 stay inactive.
- R4: The 10-bit duty D is {duty register (address 1), control bits 5:4}, with the register as the upper 8 bits.
- R5: A duty write during a period does not change that period's waveform. The new value applies from the next restart onward.
- R6: Control bits 7:6 = 01 (half-bridge) drives pin 0 with the waveform and pin 1 with its complement. Both pins are held inactive for G clocks after each transition, where G is the dead-gap register (address 3). With divider /1, pin 0 is active D−G clocks and pin 1 is active 4(P+1)−D−G clocks per period, and the two pins are never active together. Pins 2 and 3 stay inactive.
- R7: Control bits 7:6 = 10 (forward) holds pin 0 steadily active and modulates pin 3. Pins 1 and 2 stay inactive.
- R8: Control bits 7:6 = 11 (reverse) holds pin 2 steadily active and modulates pin 1. Pins 0 and 3 stay inactive.
- R9: Control bit i (i = 0..3) set makes pin i active-low, meaning that pin's level is inverted relative to active-high. When the bit is clear, pin i is active-high. The inactive level of each pin is the opposite of its active level.
- R10: Status bit 0 (address 5, also on `period_flag`) is set at every restart. Writing 0 to it clears it, and writing 1 has no effect.
- R11: While the enable bit is 0, the count holds its value and no restart occurs.
- R12: A duty of 0 leaves the waveform inactive for the whole period. A duty at or above 4(P+1) leaves it active for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pwm_out | output | 4 | Output pins 0..3 (A..D) |
| period_flag | output | 1 | Period-complete flag |

## Verification
The checker watches the steering on every cycle. It confirms that half-bridge pins never overlap, that the steady and idle pins of the single and full-bridge modes sit at the right level for the current polarity, that every restart sets the flag and zeroes the count, and that a disabled timer holds its count. Other behaviour only shows up in whole-period waveforms, so the bench scenarios cover it: the exact active-clock counts for each duty, the dead-gap widths, the deferred effect of a mid-period duty write, and the period length under each divider.

// File: rtl/steer_pwm_pkg.sv
package steer_pwm_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned PIN_N  = 4;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_HALF   = 2'b01,
        MODE_FWD    = 2'b10,
        MODE_REV    = 2'b11
    } steer_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_PERIOD = 3'd0,
        RA_DUTY   = 3'd1,
        RA_CTRL   = 3'd2,
        RA_GAP    = 3'd3,
        RA_TIMER  = 3'd4,
        RA_STATUS = 3'd5,
        RA_COUNT  = 3'd6
    } reg_addr_e;

endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
    import steer_pwm_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned FRAC_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [CNT_W-1:0]        wdata,
    output logic [CNT_W-1:0]        rdata,
    input  logic                    flag_set,
    input  logic [CNT_W-1:0]        count,
    output logic [CNT_W-1:0]        period_o,
    output logic [CNT_W+FRAC_W-1:0] duty_o,
    output steer_mode_e             mode_o,
    output logic [PIN_N-1:0]        pol_o,
    output logic [CNT_W-1:0]        gap_o,
    output logic                    en_o,
    output logic [1:0]              psel_o,
    output logic                    flag_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  period;
        logic [CNT_W-1:0]  duty_hi;
        steer_mode_e       mode;
        logic [FRAC_W-1:0] duty_lo;
        logic [PIN_N-1:0]  pol;
        logic [CNT_W-1:0]  gap;
        logic              en;
        logic [1:0]        psel;
        logic              flag;
    } regs_t;

    regs_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (reg_addr_e'(addr))
                RA_PERIOD: cfg_d.period  = wdata;
                RA_DUTY:   cfg_d.duty_hi = wdata;
                RA_CTRL: begin
                    cfg_d.mode    = steer_mode_e'(wdata[CNT_W-1 -: 2]);
                    cfg_d.duty_lo = wdata[PIN_N +: FRAC_W];
                    cfg_d.pol     = wdata[PIN_N-1:0];
                end
                RA_GAP:    cfg_d.gap = wdata;
                RA_TIMER: begin
                    cfg_d.en   = wdata[2];
                    cfg_d.psel = wdata[1:0];
                end
                RA_STATUS: if (!wdata[0]) cfg_d.flag = 1'b0;
                default: ;
            endcase
        end
        if (flag_set) cfg_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            cfg_q.period <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            RA_PERIOD: rdata = cfg_q.period;
            RA_DUTY:   rdata = cfg_q.duty_hi;
            RA_CTRL:   rdata = {cfg_q.mode, cfg_q.duty_lo, cfg_q.pol};
            RA_GAP:    rdata = cfg_q.gap;
            RA_TIMER:  rdata = {{(CNT_W-3){1'b0}}, cfg_q.en, cfg_q.psel};
            RA_STATUS: rdata = {{(CNT_W-1){1'b0}}, cfg_q.flag};
            RA_COUNT:  rdata = count;
            default:   rdata = '0;
        endcase
    end

    assign period_o = cfg_q.period;
    assign duty_o   = {cfg_q.duty_hi, cfg_q.duty_lo};
    assign mode_o   = cfg_q.mode;
    assign pol_o    = cfg_q.pol;
    assign gap_o    = cfg_q.gap;
    assign en_o     = cfg_q.en;
    assign psel_o   = cfg_q.psel;
    assign flag_o   = cfg_q.flag;

endmodule

// File: rtl/spwm_timebase.sv
module spwm_timebase #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned FRAC_W  = 2,
    parameter int unsigned DIV_MID = 4,
    parameter int unsigned DIV_HI  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [1:0]              psel,
    input  logic [CNT_W-1:0]        period,
    input  logic [CNT_W+FRAC_W-1:0] duty_in,
    output logic [CNT_W-1:0]        count_o,
    output logic                    raw_o,
    output logic                    wrap_o
);

    localparam int unsigned DUTY_W = CNT_W + FRAC_W;
    localparam int unsigned PRE_W  = $clog2(DIV_HI);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [FRAC_W-1:0] sub;
        logic [CNT_W-1:0]  tmr;
        logic [DUTY_W-1:0] shadow;
    } tb_t;

    tb_t tb_d, tb_q;
    logic [PRE_W-1:0] pre_last;
    logic             sub_step;
    logic             wrap;

    always_comb begin
        case (psel)
            2'b00:   pre_last = '0;
            2'b01:   pre_last = PRE_W'(DIV_MID - 1);
            default: pre_last = PRE_W'(DIV_HI - 1);
        endcase
    end

    always_comb begin
        tb_d     = tb_q;
        wrap     = 1'b0;
        sub_step = en && (tb_q.pre >= pre_last);
        if (en) begin
            if (sub_step) begin
                tb_d.pre = '0;
                tb_d.sub = tb_q.sub + 1'b1;
                if (tb_q.sub == {FRAC_W{1'b1}}) begin
                    if (tb_q.tmr == period) begin
                        tb_d.tmr    = '0;
                        tb_d.shadow = duty_in;
                        wrap        = 1'b1;
                    end else begin
                        tb_d.tmr = tb_q.tmr + 1'b1;
                    end
                end
            end else begin
                tb_d.pre = tb_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign count_o = tb_q.tmr;
    assign raw_o   = ({tb_q.tmr, tb_q.sub} < tb_q.shadow);
    assign wrap_o  = wrap;

endmodule

// File: rtl/spwm_steer.sv
module spwm_steer
    import steer_pwm_pkg::*;
#(
    parameter int unsigned GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  steer_mode_e      mode,
    input  logic [PIN_N-1:0] pol,
    input  logic [GAP_W-1:0] gap,
    output logic [PIN_N-1:0] pins
);

    typedef struct packed {
        logic             raw;
        logic [GAP_W-1:0] gap_cnt;
        logic [PIN_N-1:0] pins;
    } st_t;

    st_t st_d, st_q;
    logic [PIN_N-1:0] act;
    logic [PIN_N-1:0] lvl;
    logic             quiet;

    always_comb begin
        st_d     = st_q;
        st_d.raw = raw;
        if (raw != st_q.raw)        st_d.gap_cnt = gap;
        else if (st_q.gap_cnt != 0) st_d.gap_cnt = st_q.gap_cnt - 1'b1;
        else                        st_d.gap_cnt = '0;
        quiet = (st_d.gap_cnt == 0);

        act = '0;
        case (mode)
            MODE_SINGLE: act[0] = raw;
            MODE_HALF: begin
                act[0] = raw  && quiet;
                act[1] = !raw && quiet;
            end
            MODE_FWD: begin
                act[0] = 1'b1;
                act[3] = raw;
            end
            MODE_REV: begin
                act[2] = 1'b1;
                act[1] = raw;
            end
            default: act = '0;
        endcase
        st_d.pins = lvl;
    end

    for (genvar i = 0; i < PIN_N; i++) begin : g_pol
        assign lvl[i] = act[i] ^ pol[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pins = st_q.pins;

endmodule

// File: rtl/steer_pwm.sv
module steer_pwm
    import steer_pwm_pkg::*;
#(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned FRAC_W  = 2,
    parameter int unsigned DIV_MID = 4,
    parameter int unsigned DIV_HI  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [CNT_W-1:0]       reg_wdata,
    output logic [CNT_W-1:0]       reg_rdata,
    output logic [PIN_N-1:0]       pwm_out,
    output logic                   period_flag
);

    localparam int unsigned DUTY_W = CNT_W + FRAC_W;

    logic [CNT_W-1:0]  cfg_period;
    logic [DUTY_W-1:0] cfg_duty;
    steer_mode_e       cfg_mode;
    logic [PIN_N-1:0]  cfg_pol;
    logic [CNT_W-1:0]  cfg_gap;
    logic              cfg_en;
    logic [1:0]        cfg_psel;
    logic              flag;
    logic [CNT_W-1:0]  tb_count;
    logic              tb_raw;
    logic              tb_wrap;

    spwm_regs #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .flag_set (tb_wrap),
        .count    (tb_count),
        .period_o (cfg_period),
        .duty_o   (cfg_duty),
        .mode_o   (cfg_mode),
        .pol_o    (cfg_pol),
        .gap_o    (cfg_gap),
        .en_o     (cfg_en),
        .psel_o   (cfg_psel),
        .flag_o   (flag)
    );

    spwm_timebase #(
        .CNT_W(CNT_W), .FRAC_W(FRAC_W), .DIV_MID(DIV_MID), .DIV_HI(DIV_HI)
    ) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_en),
        .psel    (cfg_psel),
        .period  (cfg_period),
        .duty_in (cfg_duty),
        .count_o (tb_count),
        .raw_o   (tb_raw),
        .wrap_o  (tb_wrap)
    );

    spwm_steer #(.GAP_W(CNT_W)) u_steer (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (tb_raw),
        .mode  (cfg_mode),
        .pol   (cfg_pol),
        .gap   (cfg_gap),
        .pins  (pwm_out)
    );

    assign period_flag = flag;

endmodule

// File: rtl/spwm_chk.sv
module spwm_chk
    import steer_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [PIN_N-1:0] pol,
    input logic [PIN_N-1:0] pins,
    input logic             wrap,
    input logic             flag,
    input logic [CNT_W-1:0] count,
    input logic             en
);

    // R6: complementary pair never both active
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALF) |=>
            !((pins[0] != $past(pol[0])) && (pins[1] != $past(pol[1]))));

    // R3: single mode leaves pins 1..3 at their inactive level
    a_r3_single_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SINGLE) |=> (pins[3:1] == $past(pol[3:1])));

    // R7: forward holds pin 0 active, pins 1 and 2 inactive
    a_r7_fwd_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FWD) |=>
            (pins[0] != $past(pol[0])) && (pins[1] == $past(pol[1]))
            && (pins[2] == $past(pol[2])));

    // R8: reverse holds pin 2 active, pins 0 and 3 inactive
    a_r8_rev_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_REV) |=>
            (pins[2] != $past(pol[2])) && (pins[0] == $past(pol[0]))
            && (pins[3] == $past(pol[3])));

    // R10: every restart raises the flag
    a_r10_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);

    // R2: a restart returns the count to zero
    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == 0));

    // R11: disabled timer holds its count
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count == $past(count)));

endmodule

bind steer_pwm spwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (cfg_mode),
    .pol   (cfg_pol),
    .pins  (pwm_out),
    .wrap  (tb_wrap),
    .flag  (flag),
    .count (tb_count),
    .en    (cfg_en)
);

// File: tb/sim_steer_pwm.sv
`timescale 1ns/1ps
module sim_steer_pwm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] pwm_out;
    logic       period_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        string tag;
        int    cnt [4];
    } exp_t;

    exp_t exp_q [$];

    always #2.5 clk = ~clk;

    steer_pwm u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out),
        .period_flag(period_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_flag();
        while (!period_flag) @(negedge clk);
    endtask

    task automatic settle();
        wr(3'd5, 8'h00);
        wait_flag();
        wr(3'd5, 8'h00);
        wait_flag();
    endtask

    // driver side of the scoreboard
    task automatic expect_counts(input string tag, input int a, input int b,
                                 input int c, input int d);
        exp_t e;
        e.tag = tag;
        e.cnt[0] = a; e.cnt[1] = b; e.cnt[2] = c; e.cnt[3] = d;
        exp_q.push_back(e);
    endtask

    // monitor side: count active-high pin samples over one period, then compare
    task automatic measure(input int p, input int mid_at, input logic [7:0] mid_val);
        int   cnt [4];
        exp_t e;
        for (int k = 0; k < 4; k++) cnt[k] = 0;
        wait_flag();
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h00;
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            reg_we = 1'b0;
            if (i == mid_at) begin
                reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = mid_val;
            end
            for (int k = 0; k < 4; k++) cnt[k] += int'(pwm_out[k]);
        end
        reg_we = 1'b0;
        if (exp_q.size() == 0) begin
            check("scoreboard underflow", 0, 1);
        end else begin
            e = exp_q.pop_front();
            for (int k = 0; k < 4; k++)
                check($sformatf("%s pin%0d", e.tag, k), cnt[k], e.cnt[k]);
        end
    endtask

    task automatic period_len(input int exp, input string tag);
        int n;
        wait_flag();
        wr(3'd5, 8'h00);
        n = 1;
        while (!period_flag) begin @(negedge clk); n++; end
        check(tag, n, exp);
    endtask

    // ctrl byte: mode[7:6] duty_lo[5:4] pol[3:0]
    function automatic logic [7:0] ctl(input int mode, input int lo, input int pol);
        return 8'((mode << 6) | (lo << 4) | pol);
    endfunction

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 period", v, 255);
        rd(3'd1, v); check("R1 duty", v, 0);
        rd(3'd2, v); check("R1 ctrl", v, 0);
        rd(3'd3, v); check("R1 gap", v, 0);
        rd(3'd4, v); check("R1 timer", v, 0);
        rd(3'd5, v); check("R1 status", v, 0);
        rd(3'd6, v); check("R1 count", v, 0);
        check("R1 pins", int'(pwm_out), 0);

        // R3 R4 single, P=9 -> 40 clocks, D=5*4+2=22
        wr(3'd0, 8'd9);
        wr(3'd1, 8'd5);
        wr(3'd2, ctl(0, 2, 0));
        wr(3'd4, 8'h04);
        settle();
        expect_counts("R3 R4 single D22", 22, 0, 0, 0);
        measure(40, -1, 8'h00);

        // R5: mid-period write of duty upper=1 -> D=6 next period
        expect_counts("R5 deferred old", 22, 0, 0, 0);
        measure(40, 20, 8'd1);
        expect_counts("R5 deferred new", 6, 0, 0, 0);
        measure(40, -1, 8'h00);

        // R4 low bits 0: D=12
        wr(3'd1, 8'd3);
        wr(3'd2, ctl(0, 0, 0));
        settle();
        expect_counts("R4 single D12", 12, 0, 0, 0);
        measure(40, -1, 8'h00);

        // R6 half-bridge, gap 3, D=22
        wr(3'd1, 8'd5);
        wr(3'd3, 8'd3);
        wr(3'd2, ctl(1, 2, 0));
        settle();
        expect_counts("R6 half gap3", 19, 15, 0, 0);
        measure(40, -1, 8'h00);

        // R7 forward D=22
        wr(3'd2, ctl(2, 2, 0));
        settle();
        expect_counts("R7 forward", 40, 0, 0, 22);
        measure(40, -1, 8'h00);

        // R8 reverse D=10
        wr(3'd1, 8'd2);
        wr(3'd2, ctl(3, 2, 0));
        settle();
        expect_counts("R8 reverse", 0, 10, 40, 0);
        measure(40, -1, 8'h00);

        // R9 forward, all active-low, D=22
        wr(3'd1, 8'd5);
        wr(3'd2, ctl(2, 2, 15));
        settle();
        expect_counts("R9 polarity low", 0, 40, 40, 18);
        measure(40, -1, 8'h00);

        // R9 mixed polarity in single: pin0 low-active, pin2 low-active
        wr(3'd2, ctl(0, 2, 5));
        settle();
        expect_counts("R9 polarity mixed", 18, 0, 40, 0);
        measure(40, -1, 8'h00);

        // R12 saturation and zero
        wr(3'd1, 8'd200);
        wr(3'd2, ctl(0, 0, 0));
        settle();
        expect_counts("R12 full", 40, 0, 0, 0);
        measure(40, -1, 8'h00);
        wr(3'd1, 8'd0);
        settle();
        expect_counts("R12 zero", 0, 0, 0, 0);
        measure(40, -1, 8'h00);

        // R10 flag write semantics
        wait_flag();
        wr(3'd5, 8'h00);
        rd(3'd5, v); check("R10 cleared", v, 0);
        check("R10 port cleared", int'(period_flag), 0);
        wait_flag();
        wr(3'd5, 8'h01);
        rd(3'd5, v); check("R10 write1 no effect", v, 1);

        // R2 period lengths
        wr(3'd0, 8'd2);
        wr(3'd4, 8'h05);
        settle();
        period_len(48, "R2 div4 P2");
        wr(3'd0, 8'd0);
        wr(3'd4, 8'h06);
        settle();
        period_len(64, "R2 div16 P0");
        wr(3'd4, 8'h07);
        settle();
        period_len(64, "R2 div16 code11");
        wr(3'd0, 8'd9);
        wr(3'd4, 8'h04);
        settle();
        period_len(40, "R2 div1 P9");

        // R11 disable holds count, no restart
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h00);
        rd(3'd6, v);
        begin
            int v2;
            repeat (300) @(negedge clk);
            rd(3'd6, v2);
            check("R11 count held", v2, v);
        end
        check("R11 no flag", int'(period_flag), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule